// File: doc/BRIEF.md
# Four-Channel Low-Side Fault Supervisor

This block is the protection controller that sits between the output command register of a four-channel low-side switch and the gate drivers. On every cycle of the system clock it takes the command bit of each channel together with digital flags from the analog sense circuits. These flags are a per-channel overcurrent flag, a per-channel "pin below threshold" flag used for open-load sensing, a die overtemperature flag and a supply undervoltage flag. From them it decides which gates may be driven.

Each channel is a three-state machine with the states `CH_OFF`, `CH_ON` and `CH_RETRY`. The transitions are:
- OFF to ON when the command bit is high.
- ON to OFF when the command bit drops.
- ON to RETRY when the overcurrent deglitch expires.
- RETRY to ON when the retry timer runs out.
- RETRY to OFF when the command bit drops.

Each channel also keeps two fault latches, and the two clear under opposite conditions. The overcurrent latch clears when the command drops. The open-load latch clears when the command rises. The OR of the two latches forms the channel's readback fault bit for the serial path, and any set latch, or overtemperature, pulls the active-low fault pin. The deglitch and retry intervals are given as clock-cycle counts. At a 50 MHz clock the defaults are 175, 750 and 60000 cycles, which correspond to about 3.5 µs, 15 µs and 1.2 ms.

Top module: `chan_fault_sup`

## Requirements
- R1: A clock edge with `rst` high returns every channel to `CH_OFF` with both of its fault latches cleared, so `gate_en` is 0, `fault_bit` is 0 and `fault_n` is 1 after that edge, whatever the other inputs are.
- R2: With no fault and no overtemperature or undervoltage, `gate_en[i]` becomes 1 one edge after `cmd_on[i]` is sampled high, and becomes 0 one edge after it is sampled low.
- R3: While a channel is in `CH_ON` with its command high, `oc_flag[i]` sampled high on `OCP_DGL_CYC` consecutive edges turns the gate off and sets `fault_bit[i]` at the last of those edges. Any low sample restarts the count from zero.
- R4: After an overcurrent trip, the gate stays off for exactly `RETRY_CYC` cycles. The next edge then clears the overcurrent latch and turns the gate on again, provided the command is still high.
- R5: An edge with `cmd_on[i]` low clears that channel's overcurrent latch, including during the retry wait, which it abandons.
- R6: Only while a channel is in `CH_OFF` with its command low, `olv_flag[i]` sampled high on `OL_DGL_CYC` consecutive edges sets `fault_bit[i]`. A low sample restarts the count. The flag is ignored while the channel is on.
- R7: An edge with `cmd_on[i]` high clears that channel's open-load latch.
- R8: `fault_bit[i]` is the OR of the channel's two latches. `fault_n` is low whenever any `fault_bit` is 1 or `ot_flag` is 1, with no delay from `ot_flag`.
- R9: `ot_flag` high forces every `gate_en` bit to 0 in the same cycle and leaves channel state alone, so gates return as soon as it drops.
- R10: `uv_flag` high forces every `gate_en` bit to 0 in the same cycle and clears all state at the next edge. A channel whose command is high turns on again one edge after `uv_flag` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear of all state |
| cmd_on | input | NCH | Latched output command bits, bit i for channel i |
| oc_flag | input | NCH | Overcurrent flag per channel |
| olv_flag | input | NCH | Pin-below-threshold flag per channel (open-load sense) |
| ot_flag | input | 1 | Die overtemperature flag |
| uv_flag | input | 1 | Supply undervoltage flag |
| gate_en | output | NCH | Gate drive enable per channel |
| fault_bit | output | NCH | Combined fault bit per channel for serial readback |
| fault_n | output | 1 | Active-low summary fault output |

## Verification
Channel state, the latches and the counters all change on a clock edge. Command, overcurrent, open-load, reset and undervoltage-clear results are therefore due one edge after the sample that completes them. Overtemperature and undervoltage gating of `gate_en`, and overtemperature on `fault_n`, act in the same cycle. The bench drives every input on the falling edge and compares outputs 5 ns after the following rising edge, so each check sees exactly one new edge of state plus the current inputs. The vector table uses 3-, 4- and 5-cycle intervals, which puts the deglitch-restart case and the last-cycle-of-retry case inside a few rows.

// File: rtl/chsup_pkg.sv
package chsup_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ON    = 2'd1,
        CH_RETRY = 2'd2
    } ch_state_e;

    function automatic int cnt_width(input int len);
        return (len < 2) ? 1 : $clog2(len + 1);
    endfunction

endpackage

// File: rtl/chsup_deglitch.sv
module chsup_deglitch #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic arm,
    input  logic flag,
    output logic hit
);
    import chsup_pkg::*;

    localparam int W = cnt_width(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;
    logic         live;

    assign live = arm & flag;
    assign hit  = live & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (clr || !live || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DGL_RANGE: assert property (@(posedge clk) disable iff (clr)
        cnt <= LAST);                                                  // R3
    AST_DGL_RESTART: assert property (@(posedge clk) disable iff (clr)
        !live |=> cnt == '0);                                          // R6

endmodule

// File: rtl/chsup_retry.sv
module chsup_retry #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic hold,
    output logic done
);
    import chsup_pkg::*;

    localparam int W = cnt_width(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt;

    assign done = hold & (cnt == '0);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LAST;
        end else if (hold && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_RETRY_RANGE: assert property (@(posedge clk) disable iff (clr)
        cnt <= LAST);                                                  // R4
    AST_RETRY_LOAD: assert property (@(posedge clk) disable iff (clr)
        start |=> cnt == LAST);                                        // R4

endmodule

// File: rtl/chsup_channel.sv
module chsup_channel #(
    parameter int OCP_DGL = 3,
    parameter int OL_DGL  = 4,
    parameter int RETRY   = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic cmd,
    input  logic oc,
    input  logic olv,
    input  logic ot,
    input  logic uv,
    output logic gate,
    output logic fault
);
    import chsup_pkg::*;

    ch_state_e state, nstate;
    logic      ocp_lat, open_lat;
    logic      ocp_arm, ol_arm;
    logic      ocp_hit, ol_hit;
    logic      retry_hold, retry_done;

    assign ocp_arm    = (state == CH_ON) & cmd & ~ot;
    assign ol_arm     = (state == CH_OFF) & ~cmd;
    assign retry_hold = (state == CH_RETRY);

    chsup_deglitch #(.LEN(OCP_DGL)) u_ocp_dgl (
        .clk  (clk),
        .clr  (clr),
        .arm  (ocp_arm),
        .flag (oc),
        .hit  (ocp_hit)
    );

    chsup_deglitch #(.LEN(OL_DGL)) u_ol_dgl (
        .clk  (clk),
        .clr  (clr),
        .arm  (ol_arm),
        .flag (olv),
        .hit  (ol_hit)
    );

    chsup_retry #(.LEN(RETRY)) u_retry (
        .clk   (clk),
        .clr   (clr),
        .start (ocp_hit),
        .hold  (retry_hold),
        .done  (retry_done)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            CH_OFF: begin
                if (cmd) nstate = CH_ON;
            end
            CH_ON: begin
                if (!cmd)         nstate = CH_OFF;
                else if (ocp_hit) nstate = CH_RETRY;
            end
            CH_RETRY: begin
                if (!cmd)            nstate = CH_OFF;
                else if (retry_done) nstate = CH_ON;
            end
            default: nstate = CH_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state <= CH_OFF;
        end else begin
            state <= nstate;
        end
    end

    always_ff @(posedge clk) begin
        if (clr || !cmd) begin
            ocp_lat <= 1'b0;
        end else if (ocp_hit) begin
            ocp_lat <= 1'b1;
        end else if (retry_done) begin
            ocp_lat <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr || cmd) begin
            open_lat <= 1'b0;
        end else if (ol_hit) begin
            open_lat <= 1'b1;
        end
    end

    always_comb begin
        gate  = (state == CH_ON) & ~ot & ~uv;
        fault = ocp_lat | open_lat;
    end

    AST_OCP_NOT_ON: assert property (@(posedge clk) disable iff (clr)
        ocp_lat |-> state != CH_ON);                                   // R3
    AST_OCP_CMD_CLR: assert property (@(posedge clk) disable iff (clr)
        !cmd |=> !ocp_lat);                                            // R5
    AST_OPEN_CMD_CLR: assert property (@(posedge clk) disable iff (clr)
        cmd |=> !open_lat);                                            // R7
    AST_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (clr)
        $rose(open_lat) |-> $past(state) == CH_OFF);                   // R6

endmodule

// File: rtl/chan_fault_sup.sv
module chan_fault_sup #(
    parameter int NCH         = 4,
    parameter int OCP_DGL_CYC = 175,
    parameter int OL_DGL_CYC  = 750,
    parameter int RETRY_CYC   = 60000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cmd_on,
    input  logic [NCH-1:0] oc_flag,
    input  logic [NCH-1:0] olv_flag,
    input  logic           ot_flag,
    input  logic           uv_flag,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] fault_bit,
    output logic           fault_n
);
    logic clr_all;

    assign clr_all = rst | uv_flag;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        chsup_channel #(
            .OCP_DGL (OCP_DGL_CYC),
            .OL_DGL  (OL_DGL_CYC),
            .RETRY   (RETRY_CYC)
        ) u_ch (
            .clk   (clk),
            .clr   (clr_all),
            .cmd   (cmd_on[ch]),
            .oc    (oc_flag[ch]),
            .olv   (olv_flag[ch]),
            .ot    (ot_flag),
            .uv    (uv_flag),
            .gate  (gate_en[ch]),
            .fault (fault_bit[ch])
        );
    end

    always_comb begin
        fault_n = ~((|fault_bit) | ot_flag);
    end

    AST_OT_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        ot_flag |-> gate_en == '0);                                    // R9
    AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> gate_en == '0);                                    // R10
    AST_UV_CLEARS: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> fault_bit == '0);                                  // R10
    AST_FAULT_PIN: assert property (@(posedge clk) disable iff (rst)
        (|fault_bit) |-> !fault_n);                                    // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (fault_bit == '0 && gate_en == '0));                   // R1

endmodule

// File: tb/tb_chan_fault_sup.sv
module tb_chan_fault_sup;
    localparam int NCH = 4;
    localparam int NV  = 33;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] cmd_on, oc_flag, olv_flag;
    logic           ot_flag, uv_flag;
    logic [NCH-1:0] gate_en, fault_bit;
    logic           fault_n;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    chan_fault_sup #(
        .NCH(NCH), .OCP_DGL_CYC(3), .OL_DGL_CYC(4), .RETRY_CYC(5)
    ) dut (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .oc_flag(oc_flag),
        .olv_flag(olv_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
        .gate_en(gate_en), .fault_bit(fault_bit), .fault_n(fault_n)
    );

    // {cmd0, oc0, olv0, ot, uv, rst, exp_gate0, exp_fault0, exp_fault_n}
    localparam logic [8:0] VEC [NV] = '{
        9'b100000_101, // 0  R2 turn on
        9'b110000_101, // 1  R3 oc sample 1
        9'b100000_101, // 2  R3 drop restarts
        9'b110000_101, // 3  R3 count 1
        9'b110000_101, // 4  R3 count 2
        9'b110000_010, // 5  R3 trip
        9'b100000_010, // 6  R4 retry wait
        9'b100000_010, // 7  R4
        9'b100000_010, // 8  R4
        9'b100000_010, // 9  R4 last off cycle
        9'b100000_101, // 10 R4 back on, latch clear
        9'b100100_000, // 11 R9 overtemp gates off
        9'b100000_101, // 12 R9 resumes
        9'b110000_101, // 13 R3
        9'b110000_101, // 14 R3
        9'b110000_010, // 15 R3 trip again
        9'b000000_001, // 16 R5 command drop clears OCP
        9'b001000_001, // 17 R6 olv count 1
        9'b001000_001, // 18 R6 count 2
        9'b000000_001, // 19 R6 drop restarts
        9'b001000_001, // 20 R6
        9'b001000_001, // 21 R6
        9'b001000_001, // 22 R6
        9'b001000_010, // 23 R6 open latch set
        9'b101000_101, // 24 R7 command clears open latch
        9'b101000_101, // 25 R6 ignored while on
        9'b101000_101, // 26 R6
        9'b101000_101, // 27 R6
        9'b101000_101, // 28 R6
        9'b100010_001, // 29 R10 undervoltage
        9'b100000_101, // 30 R10 resume
        9'b100001_001, // 31 R1 reset
        9'b000000_001  // 32 R2 off
    };

    function automatic string row_req(input int i);
        if (i == 0 || i == 32)  return "R2";
        if (i >= 6 && i <= 10)  return "R4";
        if (i == 11 || i == 12) return "R9";
        if (i == 16)            return "R5";
        if (i == 24)            return "R7";
        if (i >= 17 && i <= 28) return "R6";
        if (i == 29 || i == 30) return "R10";
        if (i == 31)            return "R1";
        return "R3";
    endfunction

    task automatic cyc(input logic [NCH-1:0] c, input logic [NCH-1:0] o,
                       input logic [NCH-1:0] l, input logic t, input logic u,
                       input logic r);
        @(negedge clk);
        cmd_on = c; oc_flag = o; olv_flag = l; ot_flag = t; uv_flag = u; rst = r;
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [NCH-1:0] eg,
                       input logic [NCH-1:0] ef, input logic efn);
        checks++;
        if (gate_en !== eg || fault_bit !== ef || fault_n !== efn) begin
            errors++;
            $display("FAIL %s: gate=%b fault=%b fault_n=%b expected gate=%b fault=%b fault_n=%b",
                     req, gate_en, fault_bit, fault_n, eg, ef, efn);
        end
    endtask

    initial begin
        cmd_on = '0; oc_flag = '0; olv_flag = '0; ot_flag = 0; uv_flag = 0; rst = 1;
        cyc('0, '0, '0, 0, 0, 1);
        cyc('0, '0, '0, 0, 0, 1);
        chk("R1", '0, '0, 1'b1);  // R1 reset state

        for (int i = 0; i < NV; i++) begin
            cyc({3'b0, VEC[i][8]}, {3'b0, VEC[i][7]}, {3'b0, VEC[i][6]},
                VEC[i][5], VEC[i][4], VEC[i][3]);
            chk(row_req(i), {3'b0, VEC[i][2]}, {3'b0, VEC[i][1]}, VEC[i][0]);
        end

        // R3 trip then R1 reset clears the overcurrent latch
        cyc(4'b0001, 4'b0001, '0, 0, 0, 0);
        cyc(4'b0001, 4'b0001, '0, 0, 0, 0);
        cyc(4'b0001, 4'b0001, '0, 0, 0, 0);
        cyc(4'b0001, 4'b0001, '0, 0, 0, 0);
        chk("R3", '0, 4'b0001, 1'b0);
        cyc(4'b0001, '0, '0, 0, 0, 1);
        chk("R1", '0, '0, 1'b1);
        cyc(4'b0001, '0, '0, 0, 0, 0);
        chk("R2", 4'b0001, '0, 1'b1);

        // R6 open load on all channels at once, R8 pin low
        cyc('0, '0, 4'hF, 0, 0, 0);
        for (int k = 0; k < 4; k++) cyc('0, '0, 4'hF, 0, 0, 0);
        chk("R6", '0, 4'hF, 1'b0);
        // R7 commanding two channels clears only their open latches
        cyc(4'b0101, '0, 4'hF, 0, 0, 0);
        chk("R7", 4'b0101, 4'b1010, 1'b0);
        // R10 undervoltage clears remaining latches
        cyc(4'b0101, '0, '0, 0, 1, 0);
        chk("R10", '0, '0, 1'b1);
        // R8 overtemperature alone drives the pin low
        cyc(4'b0101, '0, '0, 1, 0, 0);
        chk("R8", '0, '0, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule